// File: doc/BRIEF.md
# Precise Event Sample Recorder

This block watches a stream of retiring-instruction events and keeps one sample for every N qualifying events. When a sample is due, the record is built from the eventing instruction's own fields in the same clock cycle. These fields are the instruction address, four general register values, the data address, the load latency and a free-running cycle stamp. State that arrives in later cycles never enters the record.

Records go into a small ring of slots. A write index counts the stored records, and it raises a level interrupt once it reaches a programmed fill level. One interrupt therefore covers a whole batch of samples. Software reads the slots through an indexed read port and then clears the index, which also drops the interrupt. In an optional latency mode, only load events whose latency is at or above a programmed minimum count toward the period.

Top module: `evt_sample_rec`

## Requirements
- R1: While enabled, every N-th qualifying event (N = `cfg_period`; 0 acts as 1) is recorded. After each record the count restarts, so the next record falls N qualifying events later.
- R2: A record holds the instruction address, the four register values, the data address and the latency of the event presented in the same cycle as the N-th qualifying event.
- R3: The stamp field holds a cycle count that is 0 during reset and grows by one on each clock edge after reset is released. The value stored is the count just before the edge that takes the event.
- R4: A record is written into the slot equal to `wr_index` before the write, and `wr_index` then increases by one. `wr_index` is visible one cycle after the event.
- R5: `irq` rises in the cycle after `wr_index` reaches a nonzero `cfg_irq_level`. It then stays high until a software clear.
- R6: With `cfg_lat_mode` = 1, an event qualifies only if `evt_is_load` = 1 and `evt_latency` >= `cfg_lat_min`. Non-loads and shorter loads are ignored.
- R7: A pulse on `sw_idx_clear` sets `wr_index` to 0 and drops `irq` on the next cycle.
- R8: When all 8 slots are filled, a due record is dropped. `wr_index` stays at 8, and `lost_count` increases by one, saturating at 255.
- R9: If a record is due in the same cycle as `sw_idx_clear`, the clear wins. The record goes to slot 0 and `wr_index` becomes 1.
- R10: While `cfg_enable` = 0, no event counts or is recorded, and the period count is reloaded with `cfg_period`.
- R11: After reset, `wr_index` = 0, `irq` = 0 and `lost_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Gates all counting and capture |
| cfg_period | input | 16 | Qualifying events per record |
| cfg_lat_mode | input | 1 | 1 = count only loads at or above the latency minimum |
| cfg_lat_min | input | 16 | Latency minimum in cycles |
| cfg_irq_level | input | 4 | Fill level that raises the interrupt; 0 disables it |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_is_load | input | 1 | The event is a load |
| evt_ip | input | 64 | Eventing instruction address |
| evt_regs | input | 256 | Four 64-bit register values, register 0 in the low bits |
| evt_daddr | input | 64 | Data address of the event |
| evt_latency | input | 16 | Load latency in cycles |
| sw_idx_clear | input | 1 | Software pulse that resets the write index |
| rd_slot | input | 3 | Slot selected for reading |
| rd_ip | output | 64 | Instruction address of the selected slot |
| rd_regs | output | 256 | Register values of the selected slot |
| rd_daddr | output | 64 | Data address of the selected slot |
| rd_latency | output | 16 | Latency of the selected slot |
| rd_stamp | output | 64 | Cycle stamp of the selected slot |
| wr_index | output | 4 | Number of stored records |
| irq | output | 1 | Level interrupt for buffer fill |
| lost_count | output | 8 | Saturating count of dropped records |

## Verification
A wrong period count shows up quickly. Records land on the wrong events, which the read port exposes as wrong addresses and stamps, and `wr_index` steps on the wrong event one cycle after it. A bad index or fill state shows at once on `wr_index`, `irq` or `lost_count` in the cycle after the event or clear. That includes a missing drop, an early interrupt or a clear that loses to a record. Field latching from the wrong cycle only shows when the slot is read. For that reason each batch is read back against stored expectations before the next clear.

// File: rtl/evt_sample_pkg.sv
// Shared widths and the record type of the event sample recorder.
// Assumes a 64-bit address space and a 64-bit cycle stamp.
package evt_sample_pkg;
    localparam int ADDR_W = 64;
    localparam int REG_W  = 64;
    localparam int NREGS  = 4;
    localparam int LAT_W  = 16;
    localparam int TS_W   = 64;

    typedef struct packed {
        logic [ADDR_W-1:0]           ip;
        logic [NREGS-1:0][REG_W-1:0] regs;
        logic [ADDR_W-1:0]           daddr;
        logic [LAT_W-1:0]            lat;
        logic [TS_W-1:0]             stamp;
    } sample_rec_t;
endpackage

// File: rtl/esr_period_count.sv
// Decides which events qualify and counts them down from the period.
// fire is combinational: it is high in the same cycle as the N-th
// qualifying event, so capture can use that cycle's fields.
// Assumes cfg_period is only changed while the block is disabled.
module esr_period_count #(
    parameter int PERIOD_W = 16,
    parameter int LAT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic                lat_mode,
    input  logic [LAT_W-1:0]    lat_min,
    input  logic                evt_valid,
    input  logic                evt_is_load,
    input  logic [LAT_W-1:0]    evt_latency,
    output logic                fire
);
    logic [PERIOD_W-1:0] remain_q;
    logic                qualify;
    logic                last_one;

    // Event qualifies when enabled and it passes the optional latency filter.
    always_comb begin
        qualify  = enable && evt_valid &&
                   (!lat_mode || (evt_is_load && (evt_latency >= lat_min)));
        last_one = (remain_q <= PERIOD_W'(1));
        fire     = qualify && last_one;
    end

    // Down-counter: reload while disabled or on expiry, step on each qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain_q <= '0;
        else if (!enable)  remain_q <= period;
        else if (qualify)  remain_q <= last_one ? period : remain_q - PERIOD_W'(1);
    end

    // R1
    reload_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> remain_q == $past(period));
    // R10
    disabled_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> remain_q == $past(period));
endmodule

// File: rtl/esr_snapshot.sv
// Builds a record from the eventing instruction's inputs in the current
// cycle and keeps the free-running cycle stamp.
// Assumes the register set arrives flat with register 0 in the low bits.
module esr_snapshot
    import evt_sample_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       evt_ip,
    input  logic [NREGS*REG_W-1:0]  evt_regs,
    input  logic [ADDR_W-1:0]       evt_daddr,
    input  logic [LAT_W-1:0]        evt_latency,
    output sample_rec_t             rec
);
    logic [TS_W-1:0]             stamp_q;
    logic [NREGS-1:0][REG_W-1:0] regs_v;

    // Cycle stamp: zero in reset, then one count per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_q + TS_W'(1);
    end

    // Split the flat register bus into its entries.
    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        assign regs_v[k] = evt_regs[k*REG_W +: REG_W];
    end

    // Assemble the record from this cycle's event fields.
    always_comb begin
        rec.ip    = evt_ip;
        rec.regs  = regs_v;
        rec.daddr = evt_daddr;
        rec.lat   = evt_latency;
        rec.stamp = stamp_q;
    end
endmodule

// File: rtl/esr_ring.sv
// Ring of record slots with write index, fill interrupt and lost counter.
// A software clear beats a record that is due in the same cycle, and
// that record goes to slot 0. Slot storage has no reset and is only
// meaningful below the write index.
module esr_ring
    import evt_sample_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int LOST_W = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int IDX_W  = $clog2(SLOTS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  sample_rec_t       rec,
    input  logic              sw_clear,
    input  logic [IDX_W-1:0]  irq_level,
    input  logic [SLOT_W-1:0] rd_slot,
    output sample_rec_t       rd_rec,
    output logic [IDX_W-1:0]  wr_index,
    output logic              irq,
    output logic [LOST_W-1:0] lost_count
);
    sample_rec_t       slots [SLOTS];
    logic [IDX_W-1:0]  idx_q, idx_next;
    logic [SLOT_W-1:0] wr_slot;
    logic              wr_en, full, drop, irq_q, irq_next;
    logic [LOST_W-1:0] lost_q;

    // Next index, write slot and drop decision, with clear taking priority.
    always_comb begin
        full     = (idx_q == IDX_W'(SLOTS));
        wr_en    = 1'b0;
        wr_slot  = '0;
        drop     = 1'b0;
        idx_next = idx_q;
        if (sw_clear) begin
            wr_en    = fire;
            idx_next = fire ? IDX_W'(1) : '0;
        end else if (fire && !full) begin
            wr_en    = 1'b1;
            wr_slot  = idx_q[SLOT_W-1:0];
            idx_next = idx_q + IDX_W'(1);
        end else if (fire) begin
            drop     = 1'b1;
        end
        irq_next = ((irq_q && !sw_clear) ||
                    ((irq_level != '0) && (idx_next >= irq_level)));
    end

    // Index, interrupt and lost-record state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            irq_q  <= 1'b0;
            lost_q <= '0;
        end else begin
            idx_q <= idx_next;
            irq_q <= irq_next;
            if (drop && (lost_q != {LOST_W{1'b1}})) lost_q <= lost_q + LOST_W'(1);
        end
    end

    // Slot storage write.
    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_slot] <= rec;
    end

    // Indexed read port.
    assign rd_rec     = slots[rd_slot];
    assign wr_index   = idx_q;
    assign irq        = irq_q;
    assign lost_count = lost_q;

    // R5
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !sw_clear) |=> irq_q);
    // R7
    clear_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !fire) |=> (idx_q == '0) && !irq_q);
    // R9
    clear_beats_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && fire) |=> idx_q == IDX_W'(1));
    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && fire && !sw_clear) |=> idx_q == IDX_W'(SLOTS));
    // R8
    lost_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_q == {LOST_W{1'b1}}) |=> lost_q == {LOST_W{1'b1}});
    // R4
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(SLOTS));
endmodule

// File: rtl/evt_sample_rec.sv
// Top of the precise event sample recorder: period counting, same-cycle
// snapshot and a ring of record slots with a batched fill interrupt.
// Assumes the configuration changes only while cfg_enable is low.
module evt_sample_rec
    import evt_sample_pkg::*;
#(
    parameter int SLOTS    = 8,
    parameter int PERIOD_W = 16,
    parameter int LOST_W   = 8,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int IDX_W   = $clog2(SLOTS) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_enable,
    input  logic [PERIOD_W-1:0]    cfg_period,
    input  logic                   cfg_lat_mode,
    input  logic [LAT_W-1:0]       cfg_lat_min,
    input  logic [IDX_W-1:0]       cfg_irq_level,
    input  logic                   evt_valid,
    input  logic                   evt_is_load,
    input  logic [ADDR_W-1:0]      evt_ip,
    input  logic [NREGS*REG_W-1:0] evt_regs,
    input  logic [ADDR_W-1:0]      evt_daddr,
    input  logic [LAT_W-1:0]       evt_latency,
    input  logic                   sw_idx_clear,
    input  logic [SLOT_W-1:0]      rd_slot,
    output logic [ADDR_W-1:0]      rd_ip,
    output logic [NREGS*REG_W-1:0] rd_regs,
    output logic [ADDR_W-1:0]      rd_daddr,
    output logic [LAT_W-1:0]       rd_latency,
    output logic [TS_W-1:0]        rd_stamp,
    output logic [IDX_W-1:0]       wr_index,
    output logic                   irq,
    output logic [LOST_W-1:0]      lost_count
);
    logic        fire;
    sample_rec_t snap, rd_rec;

    esr_period_count #(.PERIOD_W(PERIOD_W), .LAT_W(LAT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .period(cfg_period),
        .lat_mode(cfg_lat_mode), .lat_min(cfg_lat_min), .evt_valid(evt_valid),
        .evt_is_load(evt_is_load), .evt_latency(evt_latency), .fire(fire)
    );

    esr_snapshot u_snap (
        .clk(clk), .rst_n(rst_n), .evt_ip(evt_ip), .evt_regs(evt_regs),
        .evt_daddr(evt_daddr), .evt_latency(evt_latency), .rec(snap)
    );

    esr_ring #(.SLOTS(SLOTS), .LOST_W(LOST_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .fire(fire), .rec(snap),
        .sw_clear(sw_idx_clear), .irq_level(cfg_irq_level), .rd_slot(rd_slot),
        .rd_rec(rd_rec), .wr_index(wr_index), .irq(irq), .lost_count(lost_count)
    );

    // Break the selected record out onto the read port.
    always_comb begin
        rd_ip      = rd_rec.ip;
        rd_regs    = rd_rec.regs;
        rd_daddr   = rd_rec.daddr;
        rd_latency = rd_rec.lat;
        rd_stamp   = rd_rec.stamp;
    end

    // R10
    disabled_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !sw_idx_clear) |=> $stable(wr_index) && $stable(lost_count));
endmodule

// File: tb/test_evt_sample_rec.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models each requirement and queues
// expected records; the drain monitor pops and compares read-port data.
module test_evt_sample_rec;
    localparam real HALF = 2.5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_enable = 1'b0;
    logic [15:0]  cfg_period = '0;
    logic         cfg_lat_mode = 1'b0;
    logic [15:0]  cfg_lat_min = '0;
    logic [3:0]   cfg_irq_level = '0;
    logic         evt_valid = 1'b0;
    logic         evt_is_load = 1'b0;
    logic [63:0]  evt_ip = '0;
    logic [255:0] evt_regs = '0;
    logic [63:0]  evt_daddr = '0;
    logic [15:0]  evt_latency = '0;
    logic         sw_idx_clear = 1'b0;
    logic [2:0]   rd_slot = '0;
    logic [63:0]  rd_ip, rd_daddr, rd_stamp;
    logic [255:0] rd_regs;
    logic [15:0]  rd_latency;
    logic [3:0]   wr_index;
    logic         irq;
    logic [7:0]   lost_count;

    evt_sample_rec i_evt_sample_rec (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_period(cfg_period),
        .cfg_lat_mode(cfg_lat_mode), .cfg_lat_min(cfg_lat_min),
        .cfg_irq_level(cfg_irq_level), .evt_valid(evt_valid),
        .evt_is_load(evt_is_load), .evt_ip(evt_ip), .evt_regs(evt_regs),
        .evt_daddr(evt_daddr), .evt_latency(evt_latency),
        .sw_idx_clear(sw_idx_clear), .rd_slot(rd_slot), .rd_ip(rd_ip),
        .rd_regs(rd_regs), .rd_daddr(rd_daddr), .rd_latency(rd_latency),
        .rd_stamp(rd_stamp), .wr_index(wr_index), .irq(irq),
        .lost_count(lost_count)
    );

    always #(HALF) clk = ~clk;

    typedef struct {
        logic [2:0]   slot;
        logic [63:0]  ip;
        logic [255:0] regs;
        logic [63:0]  daddr;
        logic [15:0]  lat;
        logic [63:0]  stamp;
        string        tag;
    } exp_t;

    exp_t   sb_q[$];
    int     n_tests = 0;
    int     n_fail  = 0;
    bit     done    = 1'b0;
    longint tb_ts   = 0;
    int     m_cnt = 0, m_idx = 0, m_lost = 0, seq = 0;
    bit     m_irq = 1'b0;

    // Reference cycle count per R3.
    always @(posedge clk) begin
        if (!rst_n) tb_ts <= 0;
        else        tb_ts <= tb_ts + 1;
    end

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: presents one cycle of stimulus, updates the model, checks state.
    task automatic step(input bit v, input bit ld, input logic [15:0] lat,
                        input bit clr, input string tag);
        bit qual, fire, wr;
        int nxt;
        @(negedge clk);
        seq++;
        evt_valid    = v;
        evt_is_load  = ld;
        evt_latency  = lat;
        evt_ip       = 64'h0000_7f00_0000_0000 + 64'(seq) * 16;
        evt_regs     = {64'(seq) + 64'h300, 64'(seq) + 64'h200, 64'(seq) + 64'h100, 64'(seq)};
        evt_daddr    = 64'hdead_0000_0000 ^ (64'(seq) << 6);
        sw_idx_clear = clr;
        qual = cfg_enable && v && (!cfg_lat_mode || (ld && lat >= cfg_lat_min));
        fire = qual && (m_cnt <= 1);
        if (!cfg_enable)  m_cnt = int'(cfg_period);
        else if (qual)    m_cnt = fire ? int'(cfg_period) : m_cnt - 1;
        wr = 1'b0;
        if (clr) begin
            if (fire) begin
                sb_q.push_back('{3'd0, evt_ip, evt_regs, evt_daddr, lat, tb_ts, tag});
                wr = 1'b1;
            end
            nxt = fire ? 1 : 0;
            m_irq = 1'b0;
        end else if (fire && m_idx < 8) begin
            sb_q.push_back('{3'(m_idx), evt_ip, evt_regs, evt_daddr, lat, tb_ts, tag});
            nxt = m_idx + 1;
        end else begin
            if (fire && m_lost < 255) m_lost++;
            nxt = m_idx;
        end
        m_idx = nxt;
        if (cfg_irq_level != 0 && m_idx >= int'(cfg_irq_level)) m_irq = 1'b1;
        @(posedge clk);
        #1;
        chk({tag, " wr_index"}, 256'(wr_index), 256'(m_idx));
        chk({tag, " irq"}, 256'(irq), 256'(m_irq));
        chk({tag, " lost_count"}, 256'(lost_count), 256'(m_lost));
        evt_valid    = 1'b0;
        sw_idx_clear = 1'b0;
    endtask

    // Monitor: pops expected records and compares the read port.
    task automatic drain();
        exp_t e;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            @(negedge clk);
            rd_slot = e.slot;
            #1;
            chk({e.tag, " R2 ip"}, 256'(rd_ip), 256'(e.ip));
            chk({e.tag, " R2 regs"}, rd_regs, e.regs);
            chk({e.tag, " R2 daddr"}, 256'(rd_daddr), 256'(e.daddr));
            chk({e.tag, " R2 latency"}, 256'(rd_latency), 256'(e.lat));
            chk({e.tag, " R3 stamp"}, 256'(rd_stamp), 256'(e.stamp));
        end
    endtask

    task automatic set_cfg(input logic [15:0] per, input bit lm, input logic [15:0] lmin);
        @(negedge clk);
        cfg_enable   = 1'b0;
        cfg_period   = per;
        cfg_lat_mode = lm;
        cfg_lat_min  = lmin;
        @(posedge clk);
        #1;
        m_cnt = int'(per);
        @(negedge clk);
        cfg_enable = 1'b1;
    endtask

    initial begin
        cfg_irq_level = 4'd6;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 wr_index", 256'(wr_index), 256'd0);
        chk("R11 irq", 256'(irq), 256'd0);
        chk("R11 lost_count", 256'(lost_count), 256'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R4: period 3, every third event recorded, gaps between events
        set_cfg(16'd3, 1'b0, 16'd0);
        for (int i = 0; i < 9; i++) begin
            step(1'b1, i[0], 16'(i), 1'b0, "R1 period3");
            if (i % 4 == 1) step(1'b0, 1'b0, 16'd0, 1'b0, "R4 idle");
        end
        drain();

        // R6: latency mode, minimum 100, period 2
        set_cfg(16'd2, 1'b1, 16'd100);
        step(1'b1, 1'b1, 16'd99,  1'b0, "R6 short load");
        step(1'b1, 1'b1, 16'd100, 1'b0, "R6 load at min");
        step(1'b1, 1'b0, 16'd300, 1'b0, "R6 non-load");
        step(1'b1, 1'b1, 16'd250, 1'b0, "R6 long load");
        step(1'b1, 1'b1, 16'd50,  1'b0, "R6 short load");
        step(1'b1, 1'b1, 16'd101, 1'b0, "R6 load");
        step(1'b1, 1'b1, 16'hffff, 1'b0, "R6 max load");
        drain();

        // R5 R8: period 1 fills the ring, then drops saturate the lost counter
        set_cfg(16'd1, 1'b0, 16'd0);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 16'(i), 1'b0, "R5 fill");
        drain();
        for (int i = 0; i < 262; i++) step(1'b1, 1'b1, 16'd7, 1'b0, "R8 drop");
        repeat (3) step(1'b0, 1'b0, 16'd0, 1'b0, "R5 irq held");

        // R7: software clear alone
        step(1'b0, 1'b0, 16'd0, 1'b1, "R7 clear");
        // R9: clear and record in the same cycle
        step(1'b1, 1'b0, 16'd9, 1'b1, "R9 clear with record");
        drain();

        // R10: disabled events are ignored, then the period restarts
        @(negedge clk);
        cfg_enable = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 16'd500, 1'b0, "R10 disabled");
        set_cfg(16'd2, 1'b0, 16'd0);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 16'd3, 1'b0, "R10 reenabled");
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(HALF * 2.0 * 100000.0);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule